// File: doc/BRIEF.md
# SPI Master Transfer Engine with Odd-Ratio Clock Divider

This block runs one full-duplex SPI transfer per request as a bus master with an idle-low serial clock. A start pulse latches a parallel transmit word and a divider setting. The block then pulls its active-low slave-select low and drives the most significant bit at once. It toggles the serial clock, capturing the input line on every rising edge and moving to the next output bit after every falling edge. After the last bit it releases the data line, waits half a clock, lifts slave-select and pulses done.

The serial clock period is `1 + d` system clocks, where `d` is the divider value latched at start and a value of zero is treated as one. For an odd `d`, the low and high phases are equal. For an even `d`, the ratio is odd, so the high phase is one system clock longer than the low phase. The controller is a state machine with six states:

- ST_IDLE: waits for start.
- ST_LEAD: select low, first bit driven, clock low.
- ST_HIGH: clock high.
- ST_LOW: clock low between bits.
- ST_TRAIL: clock low, data released, select still low.
- ST_DONE: select high, done pulse.

The transitions are:

- IDLE→LEAD on start.
- LEAD→HIGH and LOW→HIGH when the low-phase timer expires; these are the rising edges, where the input is sampled.
- HIGH→LOW when the high-phase timer expires and bits remain; this is the falling edge, where the output shifts.
- HIGH→TRAIL when the high-phase timer expires on the last bit.
- TRAIL→DONE when the low-phase timer expires.
- DONE→IDLE unconditionally.

Top module: `spi_cs_master`

## Requirements
- R1: Out of reset and whenever busy is low, ss_n_o is 1, sclk_o is 0, mosi_oe_o is 0 and done_o is 0.
- R2: With d = div_i latched at start (0 is replaced by 1), every sclk_o high phase lasts (d>>1)+1 clocks and every low phase between rising edges lasts (d+1)>>1 clocks.
- R3: ss_n_o falls with mosi_oe_o high, sclk_o low and mosi_o equal to bit WORD_W-1 of the transmit word, and sclk_o stays low for (d+1)>>1 clocks before its first rise.
- R4: Exactly WORD_W rising edges occur per transfer. The bits seen on mosi_o at those edges, in order, equal the transmit word MSB first, and mosi_o changes only after falling edges.
- R5: miso_i is sampled at each rising edge, and the first sample lands in bit WORD_W-1 of rx_word_o. rx_word_o is updated in the done cycle and holds afterwards.
- R6: mosi_oe_o is high from the fall of ss_n_o until the falling edge that ends bit 0, and low after it. While mosi_oe_o is low, mosi_o is 0.
- R7: ss_n_o rises (d+1)>>1 clocks after the last falling edge, in the same cycle as a single-cycle done_o pulse.
- R8: start_i is ignored while busy_o is high; a new word or divider presented then neither starts a frame nor alters the running one.
- R9: busy_o rises the cycle after an accepted start and stays high through the done cycle, then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| div_i | input | DIV_W | Divider value d, clock period 1+d |
| tx_word_i | input | WORD_W | Word to transmit |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_word_o | output | WORD_W | Received word |
| sclk_o | output | 1 | Serial clock, idle low |
| ss_n_o | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable for mosi_o (low = high impedance) |
| miso_i | input | 1 | Serial data in |

## Verification
The bench builds the block with WORD_W = 12 and DIV_W = 6. The word length is not a power of two, so the bit counter never wraps naturally. The narrow divider lets the largest setting, 63, be reached within a short run, alongside divider values of 0, 1, 2, 3, 4, 7 and 10. This set covers the clamped zero case, the equal-phase odd settings and the uneven even settings. The bench also injects a start with a different word and a zero divider in the middle of a frame.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL,
        ST_DONE
    } spi_state_e;

endpackage

// File: rtl/spi_phase_calc.sv
// Converts a divider value into low/high phase lengths in system clocks.
module spi_phase_calc #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] div_i,
    output logic [DIV_W-1:0] low_len_o,
    output logic [DIV_W-1:0] high_len_o
);
    logic [DIV_W-1:0] d_eff;
    logic [DIV_W:0]   d_plus1;

    always_comb begin
        // zero would give a one-cycle period; clamp to divide by two
        d_eff      = (div_i == '0) ? DIV_W'(1) : div_i;
        d_plus1    = {1'b0, d_eff} + (DIV_W+1)'(1);
        low_len_o  = d_plus1[DIV_W:1];
        high_len_o = {1'b0, d_eff[DIV_W-1:1]} + DIV_W'(1);
    end
endmodule

// File: rtl/spi_phase_timer.sv
// Down counter: loaded with a length L, reports expiry on the L-th cycle.
module spi_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/spi_shift_unit.sv
// Transmit and receive shift registers plus the received-word holding register.
module spi_shift_unit #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              shift_i,
    input  logic              sample_i,
    input  logic              miso_i,
    input  logic              commit_i,
    output logic              mosi_bit_o,
    output logic [WORD_W-1:0] rx_word_o
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_sh_q;
    logic [WORD_W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load_i) begin
            tx_q <= tx_word_i;
        end else if (shift_i) begin
            tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh_q <= '0;
        end else if (sample_i) begin
            rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (commit_i) begin
            rx_q <= rx_sh_q;
        end
    end

    assign mosi_bit_o = tx_q[WORD_W-1];
    assign rx_word_o  = rx_q;
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
    import spi_cs_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              sclk_o,
    output logic              ss_n_o,
    output logic              mosi_o,
    output logic              mosi_oe_o,
    input  logic              miso_i
);
    localparam int BIT_W = $clog2(WORD_W);

    spi_state_e        state_q, state_d;
    logic [DIV_W-1:0]  lo_calc, hi_calc;
    logic [DIV_W-1:0]  lo_q, hi_q;
    logic [DIV_W-1:0]  tmr_len;
    logic              tmr_load, tmr_expired;
    logic              accept, do_shift, do_sample, do_commit;
    logic [BIT_W-1:0]  bit_q;
    logic              tx_bit;

    spi_phase_calc #(.DIV_W(DIV_W)) i_calc (
        .div_i      (div_i),
        .low_len_o  (lo_calc),
        .high_len_o (hi_calc)
    );

    spi_phase_timer #(.CNT_W(DIV_W)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .len_i     (tmr_len),
        .expired_o (tmr_expired)
    );

    spi_shift_unit #(.WORD_W(WORD_W)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .tx_word_i  (tx_word_i),
        .shift_i    (do_shift),
        .sample_i   (do_sample),
        .miso_i     (miso_i),
        .commit_i   (do_commit),
        .mosi_bit_o (tx_bit),
        .rx_word_o  (rx_word_o)
    );

    // next-state and datapath strobes
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_len   = lo_q;
        accept    = 1'b0;
        do_shift  = 1'b0;
        do_sample = 1'b0;
        do_commit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_LEAD;
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_len  = lo_calc;
                end
            end
            ST_LEAD, ST_LOW: begin
                if (tmr_expired) begin
                    state_d   = ST_HIGH;
                    do_sample = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_len   = hi_q;
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_len  = lo_q;
                    if (bit_q == '0) begin
                        state_d = ST_TRAIL;
                    end else begin
                        state_d  = ST_LOW;
                        do_shift = 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (tmr_expired) begin
                    state_d   = ST_DONE;
                    do_commit = 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // per-frame configuration and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= DIV_W'(1);
            hi_q  <= DIV_W'(1);
            bit_q <= '0;
        end else if (accept) begin
            lo_q  <= lo_calc;
            hi_q  <= hi_calc;
            bit_q <= BIT_W'(WORD_W - 1);
        end else if (do_shift) begin
            bit_q <= bit_q - BIT_W'(1);
        end
    end

    // outputs decoded from state
    always_comb begin
        sclk_o    = 1'b0;
        ss_n_o    = 1'b1;
        mosi_oe_o = 1'b0;
        busy_o    = 1'b1;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_LEAD, ST_LOW: begin
                ss_n_o    = 1'b0;
                mosi_oe_o = 1'b1;
            end
            ST_HIGH: begin
                ss_n_o    = 1'b0;
                mosi_oe_o = 1'b1;
                sclk_o    = 1'b1;
            end
            ST_TRAIL: ss_n_o = 1'b0;
            ST_DONE:  done_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
        mosi_o = mosi_oe_o & tx_bit;
    end
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic sclk_o,
    input logic ss_n_o,
    input logic mosi_o,
    input logic mosi_oe_o
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ss_n_o && !sclk_o && !mosi_oe_o && !done_o));

    // R3
    select_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n_o) |-> (mosi_oe_o && !sclk_o));

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R6
    sclk_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> (mosi_oe_o && !ss_n_o));

    // R6
    hiz_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mosi_oe_o |-> !mosi_o);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ss_n_o && busy_o));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

bind spi_cs_master spi_cs_master_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .sclk_o    (sclk_o),
    .ss_n_o    (ss_n_o),
    .mosi_o    (mosi_o),
    .mosi_oe_o (mosi_oe_o)
);

// File: tb/test_spi_cs_master.sv
module test_spi_cs_master;
    localparam int W  = 12;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] div = '0;
    logic [W-1:0]  tx = '0;
    logic          miso = 1'b0;
    logic          busy, done, sclk, ss_n, mosi, oe;
    logic [W-1:0]  rx;

    always #2.5 clk = ~clk;

    spi_cs_master #(.WORD_W(W), .DIV_W(DW)) i_spi_cs_master (
        .clk(clk), .rst_n(rst_n), .start_i(start), .div_i(div),
        .tx_word_i(tx), .busy_o(busy), .done_o(done), .rx_word_o(rx),
        .sclk_o(sclk), .ss_n_o(ss_n), .mosi_o(mosi), .mosi_oe_o(oe),
        .miso_i(miso)
    );

    typedef struct {
        logic [W-1:0] txw;
        logic [W-1:0] slv;
        int           lo;
        int           hi;
    } item_t;

    item_t q[$];
    int n_tests = 0;
    int n_fail  = 0;
    int pushes  = 0;
    int frames  = 0;
    int cycles  = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor and slave model: sampled on the falling system-clock edge
    logic         psclk = 1'b0;
    logic         pss   = 1'b1;
    int           run, falls, rises;
    bit           tbad, obad, have;
    logic [W-1:0] cap, sh;
    item_t        cur;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ss_n && pss) begin
                frames++;
                have = (q.size() > 0);
                check(have, "R8 frame without request", 1, 0);
                if (have) cur = q[0];
                run = 1; falls = 0; rises = 0; tbad = 0; obad = 0; cap = '0;
                sh = cur.slv;
                miso = sh[W-1];
                // R3 first bit driven before the first rising edge
                check(oe && !sclk && mosi == cur.txw[W-1], "R3 lead data", {oe, sclk, mosi}, {2'b10, cur.txw[W-1]});
            end else if (!ss_n) begin
                if (sclk == psclk) begin
                    run++;
                end else begin
                    if (psclk ? (run != cur.hi) : (run != cur.lo)) tbad = 1;
                    run = 1;
                    if (sclk) begin
                        rises++;
                        cap = {cap[W-2:0], mosi};
                    end else begin
                        falls++;
                        sh = sh << 1;
                        miso = sh[W-1];
                    end
                end
                if ((falls < W) != oe) obad = 1;
            end else if (!pss && have) begin
                check(run == cur.lo, "R7 trailing low length", run, cur.lo);
                check(!tbad, "R2 phase lengths", tbad, 0);
                check(rises == W, "R4 rising edge count", rises, W);
                check(cap == cur.txw, "R4 mosi word", cap, cur.txw);
                check(!obad, "R6 output enable window", obad, 0);
                check(rx == cur.slv, "R5 received word", rx, cur.slv);
                check(done && busy, "R7 done with select rise", {done, busy}, 2'b11);
                void'(q.pop_front());
            end
            psclk = sclk;
            pss   = ss_n;
        end
    end

    // driver: pushes the expected frame and issues the start
    task automatic xfer(input logic [W-1:0] t, input logic [W-1:0] s, input int dv, input bit poke);
        item_t it;
        int d;
        d = (dv == 0) ? 1 : dv;
        it.txw = t; it.slv = s; it.lo = (d + 1) / 2; it.hi = d / 2 + 1;
        q.push_back(it);
        pushes++;
        @(negedge clk);
        tx = t; div = DW'(dv); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R9 busy after start", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            tx = ~t; div = '0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            tx = '0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        check(!done && !busy, "R9 done single and busy low", {done, busy}, 0);
        check(rx == s, "R5 received word held", rx, s);
        check(ss_n && !sclk && !oe, "R1 idle pins after frame", {ss_n, sclk, oe}, 3'b100);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(ss_n && !sclk && !oe && !busy && !done, "R1 reset state",
              {ss_n, sclk, oe, busy, done}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        xfer(12'hA5B, 12'h3C1, 0, 0);   // clamped divider
        xfer(12'hF0F, 12'h0A5, 1, 0);
        xfer(12'h123, 12'hFED, 2, 0);   // uneven phases
        xfer(12'h800, 12'h001, 3, 0);
        xfer(12'h7FF, 12'h800, 4, 1);   // R8 start while busy
        xfer(12'hC3C, 12'h5A5, 7, 0);
        xfer(12'h001, 12'hFFF, 10, 0);
        xfer(12'hABC, 12'h555, 63, 0);
        repeat (20) @(negedge clk);
        check(frames == pushes, "R8 frame count", frames, pushes);
        check(!busy && ss_n, "R8 no extra frame", {busy, ss_n}, 2'b01);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule